// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Aligner

This block sits between the load/store stage of a processor core and a data memory that is 32 bits wide and addressed in bytes. Each request carries a byte address, an access size, a load/store select, a signedness bit and store data.

For a store, the block produces three things for the memory: a word-aligned address, a per-lane byte-enable mask, and write data with the store value copied into every lane that could receive it. For a load, it issues the aligned address. In the next cycle the memory returns a word, and the block picks the addressed byte or halfword from it and widens it to 32 bits.

Lanes follow big-endian order. The lowest byte address within a word is the most significant byte. An access that breaks natural alignment raises a flag and reaches neither the memory nor the load result.

Top module: `be_ls_aligner`

## Requirements
- R1: `mem_addr` equals `req_addr` with its two low bits forced to zero.
- R2: Size encoding is 2'b00 for a byte. An accepted byte store asserts exactly one enable: offset 0 gives `mem_be`=4'b1000, offset 1 gives 4'b0100, offset 2 gives 4'b0010 and offset 3 gives 4'b0001. `mem_be[3]` guards data bits 31:24.
- R3: Size encoding is 2'b01 for a halfword. An accepted halfword store at offset 0 gives `mem_be`=4'b1100, and at offset 2 it gives 4'b0011.
- R4: Size encoding is 2'b10 for a word. An accepted word store gives `mem_be`=4'b1111, and `mem_wdata` equals `req_wdata`.
- R5: A byte store drives `mem_wdata` with `req_wdata[7:0]` in all four lanes. A halfword store drives `req_wdata[15:0]` in both halves.
- R6: `misalign` is high for a valid request in any of these cases: a halfword at an odd offset, a word at a nonzero offset, or the reserved size 2'b11. A byte is never misaligned.
- R7: A misaligned request leaves `mem_en`, `mem_we` and `mem_be` all zero, and it never produces `ld_valid`.
- R8: `ld_data` for a byte load is the lane picked by big-endian offset. A load with `req_signed`=1 sign-extends the lane, and a load with `req_signed`=0 zero-extends it.
- R9: `ld_data` for a halfword load is bits 31:16 at offset 0 or bits 15:0 at offset 2, extended according to `req_signed`.
- R10: A word load returns `mem_rdata` unchanged.
- R11: `ld_valid` is high for exactly the one cycle after an accepted load and is low after reset. `mem_rdata` is sampled in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend a sub-word load |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store value, right-justified |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Word returned by memory one cycle after a read |
| misalign | output | 1 | Request breaks natural alignment |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The hardest situation to reach is a load whose extraction depends on the context captured one cycle earlier. The lane data arrives only after the request has been replaced by something else.

To reach it, the bench issues each load and then drops the request on the next falling edge. It drives a return word whose every lane has a distinct sign bit, so a stale offset or signedness would show up in `ld_data`.

The bench also follows a misaligned load with the same return word, to show that no result appears for it.

// File: rtl/be_lsa_pkg.sv
package be_lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/be_align_check.sv
module be_align_check
  import be_lsa_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] off,
  input  acc_size_e        size,
  output logic             bad
);
  always_comb begin
    unique case (size)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = off[0];
      SZ_WORD: bad = |off;
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/be_store_path.sv
module be_store_path
  import be_lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              st_en,
  input  logic [OFF_W-1:0]  off,
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata_out
);
  localparam int HALVES = LANES / 2;

  // lane at byte offset l sits at be[LANES-1-l] (big-endian)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFF_W-1:0] LOFF = OFF_W'(l);
    logic hit;
    always_comb begin
      unique case (size)
        SZ_BYTE: hit = (off == LOFF);
        SZ_HALF: hit = (off[OFF_W-1:1] == LOFF[OFF_W-1:1]);
        SZ_WORD: hit = 1'b1;
        default: hit = 1'b0;
      endcase
    end
    assign be[LANES-1-l] = st_en & hit;
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: wdata_out = {LANES{wdata_in[7:0]}};
      SZ_HALF: wdata_out = {HALVES{wdata_in[15:0]}};
      default: wdata_out = wdata_in;
    endcase
  end
endmodule

// File: rtl/be_load_path.sv
module be_load_path
  import be_lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [OFF_W-1:0]  cap_off,
  input  acc_size_e         cap_size,
  input  logic              cap_sext,
  input  logic [DATA_W-1:0] rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  localparam int HALVES = LANES / 2;

  logic             vld_q, vld_d;
  logic [OFF_W-1:0] off_q, off_d;
  acc_size_e        size_q, size_d;
  logic             sext_q, sext_d;

  always_comb begin
    vld_d  = cap_en;
    off_d  = off_q;
    size_d = size_q;
    sext_d = sext_q;
    if (cap_en) begin
      off_d  = cap_off;
      size_d = cap_size;
      sext_d = cap_sext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      off_q  <= '0;
      size_q <= SZ_WORD;
      sext_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      off_q  <= off_d;
      size_q <= size_d;
      sext_q <= sext_d;
    end
  end

  logic [7:0]  lane_b [LANES];
  logic [15:0] lane_h [HALVES];
  for (genvar l = 0; l < LANES; l++) begin : g_bsel
    assign lane_b[l] = rdata[DATA_W-1-8*l -: 8];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_hsel
    assign lane_h[h] = rdata[DATA_W-1-16*h -: 16];
  end

  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  assign byte_sel = lane_b[off_q];
  assign half_sel = lane_h[off_q[OFF_W-1:1]];

  always_comb begin
    unique case (size_q)
      SZ_BYTE: ld_data = {{(DATA_W-8){sext_q & byte_sel[7]}}, byte_sel};
      SZ_HALF: ld_data = {{(DATA_W-16){sext_q & half_sel[15]}}, half_sel};
      default: ld_data = rdata;
    endcase
  end

  assign ld_valid = vld_q;

  assert_word_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && size_q == SZ_WORD) |-> (ld_data == rdata));

  assert_byte_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && size_q == SZ_BYTE && !sext_q) |-> (ld_data[DATA_W-1:8] == '0));

  assert_half_sext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && size_q == SZ_HALF && sext_q && ld_data[15]) |-> (&ld_data[DATA_W-1:16]));
endmodule

// File: rtl/be_ls_aligner.sv
module be_ls_aligner
  import be_lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              misalign,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  acc_size_e        size;
  logic [OFF_W-1:0] off;
  logic             bad;
  logic             accept;

  assign size = acc_size_e'(req_size);
  assign off  = req_addr[OFF_W-1:0];

  be_align_check #(.OFF_W(OFF_W)) align_i (
    .off  (off),
    .size (size),
    .bad  (bad)
  );

  assign misalign = req_valid & bad;
  assign accept   = req_valid & ~bad;
  assign mem_en   = accept;
  assign mem_we   = accept & req_store;
  assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  be_store_path #(.DATA_W(DATA_W)) st_i (
    .st_en     (accept & req_store),
    .off       (off),
    .size      (size),
    .wdata_in  (req_wdata),
    .be        (mem_be),
    .wdata_out (mem_wdata)
  );

  be_load_path #(.DATA_W(DATA_W)) ld_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (accept & ~req_store),
    .cap_off  (off),
    .cap_size (size),
    .cap_sext (req_signed),
    .rdata    (mem_rdata),
    .ld_valid (ld_valid),
    .ld_data  (ld_data)
  );

  assert_quiet_on_misalign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_en && !mem_we && mem_be == '0));

  assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && size == SZ_BYTE) |-> ($countones(mem_be) == 1));

  assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && size == SZ_HALF) |-> ($countones(mem_be) == 2));

  assert_ldvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !misalign) |=> ld_valid);

  assert_no_ld_after_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en || mem_we) |=> !ld_valid);
endmodule

// File: tb/be_ls_aligner_tb.sv
module be_ls_aligner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, req_signed;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata, mem_rdata;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic        mem_en, mem_we, misalign, ld_valid;
  logic [3:0]  mem_be;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  be_ls_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_store(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] exp_be, input logic [31:0] exp_d, input bit bad);
    @(negedge clk);
    req_valid = 1; req_store = 1; req_size = sz; req_signed = 0;
    req_addr = a; req_wdata = d;
    #1;
    check("R1 mem_addr", mem_addr, {a[31:2], 2'b00});
    check("R6 misalign", {31'd0, misalign}, {31'd0, bad});
    if (bad) begin
      check("R7 be zero", {28'd0, mem_be}, 32'd0);
      check("R7 en/we zero", {30'd0, mem_en, mem_we}, 32'd0);
    end else begin
      check("R2/R3/R4 mem_be", {28'd0, mem_be}, {28'd0, exp_be});
      check("R5/R4 mem_wdata", mem_wdata, exp_d);
      check("R4 en/we", {30'd0, mem_en, mem_we}, 32'd3);
    end
  endtask

  task automatic do_load(input logic [1:0] sz, input bit sg, input logic [31:0] a,
                         input logic [31:0] rd, input logic [31:0] exp, input bit bad,
                         input string tag);
    @(negedge clk);
    req_valid = 1; req_store = 0; req_size = sz; req_signed = sg; req_addr = a;
    #1;
    check("R6 load misalign", {31'd0, misalign}, {31'd0, bad});
    @(negedge clk);
    req_valid = 0; req_addr = 32'hFFFF_FFFF; req_signed = ~sg; mem_rdata = rd;
    #1;
    check("R11/R7 ld_valid", {31'd0, ld_valid}, {31'd0, ~bad});
    if (!bad) check(tag, ld_data, exp);
  endtask

  task automatic t_reset;
    rst_n = 0; req_valid = 0; req_store = 0; req_size = 0; req_signed = 0;
    req_addr = 0; req_wdata = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    check("R11 reset ld_valid", {31'd0, ld_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R11 idle ld_valid", {31'd0, ld_valid}, 32'd0);
  endtask

  task automatic t_store_byte;
    do_store(2'b00, 32'h0000_1000, 32'h1234_56A5, 4'b1000, 32'hA5A5_A5A5, 0);
    do_store(2'b00, 32'h0000_1001, 32'h0000_003C, 4'b0100, 32'h3C3C_3C3C, 0);
    do_store(2'b00, 32'h0000_1002, 32'h0000_00FF, 4'b0010, 32'hFFFF_FFFF, 0);
    do_store(2'b00, 32'h0000_2003, 32'h0000_0001, 4'b0001, 32'h0101_0101, 0);
  endtask

  task automatic t_store_half;
    do_store(2'b01, 32'h0000_3000, 32'hDEAD_BEEF, 4'b1100, 32'hBEEF_BEEF, 0);
    do_store(2'b01, 32'h0000_3006, 32'h0000_1357, 4'b0011, 32'h1357_1357, 0);
  endtask

  task automatic t_store_word;
    do_store(2'b10, 32'hABCD_0008, 32'hCAFE_F00D, 4'b1111, 32'hCAFE_F00D, 0);
  endtask

  task automatic t_misalign;
    do_store(2'b01, 32'h0000_0001, 32'h1, 4'b0, 32'h0, 1);
    do_store(2'b01, 32'h0000_0003, 32'h1, 4'b0, 32'h0, 1);
    do_store(2'b10, 32'h0000_0002, 32'h1, 4'b0, 32'h0, 1);
    do_store(2'b10, 32'h0000_0007, 32'h1, 4'b0, 32'h0, 1);
    do_store(2'b11, 32'h0000_0000, 32'h1, 4'b0, 32'h0, 1);
  endtask

  task automatic t_load_byte;
    do_load(2'b00, 1, 32'h100, 32'h807F_F102, 32'hFFFF_FF80, 0, "R8 lb off0");
    do_load(2'b00, 0, 32'h100, 32'h807F_F102, 32'h0000_0080, 0, "R8 lbu off0");
    do_load(2'b00, 1, 32'h101, 32'h807F_F102, 32'h0000_007F, 0, "R8 lb off1");
    do_load(2'b00, 1, 32'h102, 32'h807F_F102, 32'hFFFF_FFF1, 0, "R8 lb off2");
    do_load(2'b00, 0, 32'h103, 32'h807F_F102, 32'h0000_0002, 0, "R8 lbu off3");
  endtask

  task automatic t_load_half;
    do_load(2'b01, 1, 32'h200, 32'h807F_F102, 32'hFFFF_807F, 0, "R9 lh off0");
    do_load(2'b01, 0, 32'h202, 32'h807F_F102, 32'h0000_F102, 0, "R9 lhu off2");
    do_load(2'b01, 1, 32'h202, 32'h807F_F102, 32'hFFFF_F102, 0, "R9 lh off2");
    do_load(2'b01, 1, 32'h204, 32'h7F80_0000, 32'h0000_7F80, 0, "R9 lh positive");
  endtask

  task automatic t_load_word;
    do_load(2'b10, 1, 32'h300, 32'h807F_F102, 32'h807F_F102, 0, "R10 lw");
    do_load(2'b10, 0, 32'h303, 32'h807F_F102, 32'h0, 1, "R7 lw misaligned");
    do_load(2'b01, 1, 32'h301, 32'h807F_F102, 32'h0, 1, "R7 lh misaligned");
  endtask

  initial begin
    t_reset();
    t_store_byte();
    t_store_half();
    t_store_word();
    t_misalign();
    t_load_byte();
    t_load_half();
    t_load_word();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog got=timeout exp=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule